// File: doc/BRIEF.md
# Rate Sensor Power-Up Self-Check Sequencer

This block brings an angular-rate sensor from power-on into a known, verified state before anything else talks to it. After a start pulse it waits a boot interval, then issues a fixed series of 32-bit command words through an external SPI frame engine. It inspects each returned word and finishes in READY, or in ERROR with a code that names the step that failed. Delays are counted in whole milliseconds from a 1 ms tick input. The boot and step intervals are parameters, so a simulation can shrink them.

The series has five exchanges. The first is a sensor-data command with the check and parity bits set. An unexpected reply to it only raises a warning. The second is a plain sensor-data command whose reply is thrown away. The third and fourth are plain sensor-data commands sent back to back, and both replies must carry a healthy pattern. The last is a read of the fault register pair, and any flagged fault ends the run in ERROR. The frame engine is reached through a request/done handshake. It shifts the word and later returns the reply together with a done pulse.

Top module: `gyro_boot_seq`

## Requirements
- R1: While reset is held, and after it is released, the block idles: xfer_req, busy, ready, error and warn are low and err_code is 0.
- R2: A start pulse seen while idle, READY or ERROR begins a run, and busy is high from the next cycle. A start seen while busy has no effect. A complete run issues exactly five requests.
- R3: The first request is issued only after BOOT_MS ticks have been counted following the start, and carries 0x20000003. Every request is one cycle wide.
- R4: Every command word has odd overall parity, with bit 0 as the parity bit. Exchanges two to four send 0x20000000. The fifth sends 0x80140000, which is read opcode 3'b100 in bits 31:29 and register address 0x0A in bits 24:17.
- R5: If the first reply is not exactly 0x00000001, warn is raised and stays high for the rest of the run, and the run continues.
- R6: After the first reply, STEP_MS ticks pass before the second request, and the second reply is never examined. STEP_MS ticks later the third request follows, and the fourth request is issued on the cycle right after the third reply.
- R7: A reply to exchange three or four passes only if bits 7:1 are all ones (bit 0 is ignored) and bits 27:26 equal 2'b10. A failure on exchange three ends in ERROR with err_code 1, and a failure on exchange four ends in ERROR with err_code 2.
- R8: The fifth reply fails if any of bits 16:5 is set, and the run then ends in ERROR with err_code 3. Bits outside 16:5 are ignored.
- R9: When all checks pass, ready goes high and busy goes low. READY and ERROR, together with warn and err_code, hold until the next start or reset. A restart clears them.
- R10: Reset asserted in the middle of a run returns the block to idle. No further request is made until a new start.
- R11: A done pulse that arrives while no exchange is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a power-up run |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| xfer_req | output | 1 | One-cycle request to the frame engine |
| xfer_cmd | output | 32 | Command word for the engine, held until the next request |
| xfer_done | input | 1 | Pulse from the engine: reply available |
| xfer_rdata | input | 32 | Reply word, valid with xfer_done |
| busy | output | 1 | Run in progress |
| ready | output | 1 | Run finished with all checks passed |
| error | output | 1 | Run aborted on a failed check |
| warn | output | 1 | First reply was not the expected pattern |
| err_code | output | 2 | 0 none, 1 third-exchange fail, 2 fourth-exchange fail, 3 fault register |

## Verification
The bench gives the third and fourth exchanges replies with bit 0 cleared. A checker that compares the full low byte would then abort a healthy run. It sends a bad status field on exchange three, and a bad low byte on exchange four. If the two failures were swapped or merged, the error code would come out wrong. Fault replies set only bits outside 16:5 in one case and bit 16 in another, which catches an off-by-one fault window. A start in mid-run, a stray done during the boot wait and a reset partway through would each disturb the request count or timing if they were not ignored. The bench also counts ticks before the first request, so an off-by-one delay is caught.

// File: rtl/gyro_boot_pkg.sv
package gyro_boot_pkg;

  localparam int WORD_W = 32;
  localparam int PH_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_READY,
    ST_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    EC_NONE   = 2'd0,
    EC_THIRD  = 2'd1,
    EC_FOURTH = 2'd2,
    EC_FAULT  = 2'd3
  } err_code_e;

  // exchange index within a run
  localparam logic [PH_W-1:0] PH_FIRST  = 3'd0;
  localparam logic [PH_W-1:0] PH_SETTLE = 3'd1;
  localparam logic [PH_W-1:0] PH_CHK_A  = 3'd2;
  localparam logic [PH_W-1:0] PH_CHK_B  = 3'd3;
  localparam logic [PH_W-1:0] PH_FAULT  = 3'd4;

  // command word fields
  localparam int          OPC_LSB    = 29;
  localparam logic [2:0]  OPC_SENSOR = 3'b001;
  localparam logic [2:0]  OPC_READ   = 3'b100;
  localparam int          CHECK_BIT  = 1;

  // reply fields
  localparam int          STAT_LSB   = 26;
  localparam logic [1:0]  STAT_GOOD  = 2'b10;

endpackage

// File: rtl/boot_tick_timer.sv
module boot_tick_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);

  logic [CW-1:0] remain;

  // load wins over a tick on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (tick && (remain > CW'(1))) begin
      remain <= remain - CW'(1);
    end
  end

  assign expire = tick && (remain == CW'(1));

endmodule

// File: rtl/boot_cmd_gen.sv
module boot_cmd_gen
  import gyro_boot_pkg::*;
#(
  parameter logic [7:0] FAULT_ADDR = 8'h0A,
  parameter int         ADDR_LSB   = 17
) (
  input  logic [PH_W-1:0]   idx,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] base;

  always_comb begin
    base = '0;
    case (idx)
      PH_FIRST: begin
        base[OPC_LSB +: 3] = OPC_SENSOR;
        base[CHECK_BIT]    = 1'b1;
      end
      PH_FAULT: begin
        base[OPC_LSB +: 3]  = OPC_READ;
        base[ADDR_LSB +: 8] = FAULT_ADDR;
      end
      default: begin
        base[OPC_LSB +: 3] = OPC_SENSOR;
      end
    endcase
    // bit 0 makes the total count of ones odd
    word = base | {{(WORD_W-1){1'b0}}, ~^base};
  end

endmodule

// File: rtl/boot_resp_eval.sv
module boot_resp_eval
  import gyro_boot_pkg::*;
#(
  parameter int FLT_LSB = 5,
  parameter int FLT_W   = 12
) (
  input  logic [WORD_W-1:0] rdata,
  output logic              first_ok,
  output logic              stat_ok,
  output logic              fault_clr
);

  always_comb begin
    first_ok  = (rdata == {{(WORD_W-1){1'b0}}, 1'b1});
    stat_ok   = (&rdata[7:1]) && (rdata[STAT_LSB +: 2] == STAT_GOOD);
    fault_clr = ~|rdata[FLT_LSB +: FLT_W];
  end

endmodule

// File: rtl/gyro_boot_seq.sv
module gyro_boot_seq
  import gyro_boot_pkg::*;
#(
  parameter int         BOOT_MS    = 100,
  parameter int         STEP_MS    = 50,
  parameter logic [7:0] FAULT_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick_ms,
  output logic              xfer_req,
  output logic [WORD_W-1:0] xfer_cmd,
  input  logic              xfer_done,
  input  logic [WORD_W-1:0] xfer_rdata,
  output logic              busy,
  output logic              ready,
  output logic              error,
  output logic              warn,
  output logic [1:0]        err_code
);

  localparam int MAX_MS = (BOOT_MS > STEP_MS) ? BOOT_MS : STEP_MS;
  localparam int CW     = $clog2(MAX_MS + 1);

  seq_state_e        st;
  logic [PH_W-1:0]   phase;
  logic              launch;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_expire;
  logic [PH_W-1:0]   cmd_idx;
  logic [WORD_W-1:0] cmd_word;
  logic              first_ok;
  logic              stat_ok;
  logic              fault_clr;

  always_comb begin
    launch   = start && ((st == ST_IDLE) || (st == ST_READY) || (st == ST_FAIL));
    tmr_load = launch ||
               ((st == ST_XFER) && xfer_done && (phase <= PH_SETTLE));
    tmr_val  = launch ? CW'(BOOT_MS) : CW'(STEP_MS);
    // in the transfer state the next word to send is the following exchange
    cmd_idx  = (st == ST_XFER) ? (phase + PH_W'(1)) : phase;
  end

  boot_tick_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick_ms),
    .expire   (tmr_expire)
  );

  boot_cmd_gen #(.FAULT_ADDR(FAULT_ADDR)) u_cmd (
    .idx  (cmd_idx),
    .word (cmd_word)
  );

  boot_resp_eval u_eval (
    .rdata     (xfer_rdata),
    .first_ok  (first_ok),
    .stat_ok   (stat_ok),
    .fault_clr (fault_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      phase    <= PH_FIRST;
      xfer_req <= 1'b0;
      xfer_cmd <= '0;
      busy     <= 1'b0;
      ready    <= 1'b0;
      error    <= 1'b0;
      warn     <= 1'b0;
      err_code <= EC_NONE;
    end else begin
      xfer_req <= 1'b0;
      case (st)
        ST_IDLE, ST_READY, ST_FAIL: begin
          if (launch) begin
            st       <= ST_WAIT;
            phase    <= PH_FIRST;
            busy     <= 1'b1;
            ready    <= 1'b0;
            error    <= 1'b0;
            warn     <= 1'b0;
            err_code <= EC_NONE;
          end
        end
        ST_WAIT: begin
          if (tmr_expire) begin
            st       <= ST_XFER;
            xfer_req <= 1'b1;
            xfer_cmd <= cmd_word;
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            case (phase)
              PH_FIRST: begin
                warn  <= !first_ok;
                st    <= ST_WAIT;
                phase <= PH_SETTLE;
              end
              PH_SETTLE: begin
                st    <= ST_WAIT;
                phase <= PH_CHK_A;
              end
              PH_CHK_A, PH_CHK_B: begin
                if (!stat_ok) begin
                  st       <= ST_FAIL;
                  busy     <= 1'b0;
                  error    <= 1'b1;
                  err_code <= (phase == PH_CHK_A) ? EC_THIRD : EC_FOURTH;
                end else begin
                  xfer_req <= 1'b1;
                  xfer_cmd <= cmd_word;
                  phase    <= phase + PH_W'(1);
                end
              end
              default: begin
                busy <= 1'b0;
                if (!fault_clr) begin
                  st       <= ST_FAIL;
                  error    <= 1'b1;
                  err_code <= EC_FAULT;
                end else begin
                  st    <= ST_READY;
                  ready <= 1'b1;
                end
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gyro_boot_sva.sv
module gyro_boot_sva (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        xfer_req,
  input logic [31:0] xfer_cmd,
  input logic        busy,
  input logic        ready,
  input logic        error,
  input logic [1:0]  err_code
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req); // R3

  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> busy); // R2

  AST_CMD_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (^xfer_cmd)); // R4

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(ready || error)); // R2

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ready && error)); // R9

  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    error |-> (err_code != 2'd0)); // R7

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready); // R9

  AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> (error && $stable(err_code))); // R7

endmodule

bind gyro_boot_seq gyro_boot_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .xfer_req (xfer_req),
  .xfer_cmd (xfer_cmd),
  .busy     (busy),
  .ready    (ready),
  .error    (error),
  .err_code (err_code)
);

// File: tb/sim_gyro_boot_seq.sv
module sim_gyro_boot_seq;

  localparam int PERIOD = 10;
  localparam int BOOT   = 4;
  localparam int STEP   = 3;
  localparam int TDIV   = 5;
  localparam int LAT    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        tick_ms = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] xfer_rdata = '0;
  logic        xfer_req;
  logic [31:0] xfer_cmd;
  logic        busy, ready, error, warn;
  logic [1:0]  err_code;

  int nvec = 0;
  int nbad = 0;

  always #(PERIOD/2) clk = ~clk;

  gyro_boot_seq #(.BOOT_MS(BOOT), .STEP_MS(STEP)) u0 (
    .clk(clk), .rst(rst), .start(start), .tick_ms(tick_ms),
    .xfer_req(xfer_req), .xfer_cmd(xfer_cmd),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
    .busy(busy), .ready(ready), .error(error), .warn(warn),
    .err_code(err_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          m_st = 0;   // 0 idle 1 wait 2 xfer 3 ready 4 error
  int          m_cnt = 0;
  int          m_ph = 0;
  logic        m_req = 0, m_busy = 0, m_rdy = 0, m_err = 0, m_warn = 0;
  logic [1:0]  m_code = 0;
  logic [31:0] m_cmd = 0;

  function automatic logic [31:0] cmd_for(input int ph);
    if (ph == 0) return 32'h2000_0003;
    if (ph == 4) return 32'h8014_0000;
    return 32'h2000_0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_req = 0; m_cmd = 0;
      m_busy = 0; m_rdy = 0; m_err = 0; m_warn = 0; m_code = 0;
    end else begin
      m_req = 0;
      if (m_st == 0 || m_st == 3 || m_st == 4) begin
        if (start) begin
          m_st = 1; m_cnt = BOOT; m_ph = 0; m_busy = 1;
          m_rdy = 0; m_err = 0; m_warn = 0; m_code = 0;
        end
      end else if (m_st == 1) begin
        if (tick_ms) begin
          if (m_cnt == 1) begin m_st = 2; m_req = 1; m_cmd = cmd_for(m_ph); end
          else m_cnt = m_cnt - 1;
        end
      end else if (xfer_done) begin
        if (m_ph == 0) begin
          m_warn = (xfer_rdata != 32'd1); m_st = 1; m_cnt = STEP; m_ph = 1;
        end else if (m_ph == 1) begin
          m_st = 1; m_cnt = STEP; m_ph = 2;
        end else if (m_ph == 2 || m_ph == 3) begin
          if (((xfer_rdata & 32'hFF) | 32'h1) != 32'hFF || ((xfer_rdata >> 26) & 3) != 2) begin
            m_st = 4; m_busy = 0; m_err = 1; m_code = (m_ph == 2) ? 2'd1 : 2'd2;
          end else begin
            m_req = 1; m_ph = m_ph + 1; m_cmd = cmd_for(m_ph);
          end
        end else begin
          m_busy = 0;
          if (((xfer_rdata >> 5) & 32'hFFF) != 0) begin m_st = 4; m_err = 1; m_code = 2'd3; end
          else begin m_st = 3; m_rdy = 1; end
        end
      end
    end
  end

  // ---------------- stimulus, frame-engine stand-in, compare ----------------
  logic [31:0] resp_q[$];
  int  cmd_log[$];
  int  req_cyc[$];
  int  done_cyc[$];
  int  cyc = 0;
  int  pend = 0;
  int  tks = 0;
  int  first_ticks = -1;
  int  start_tok = 0, start_seen = 0;
  int  inj_tok = 0, inj_seen = 0;
  bit  cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 busy", 32'(busy), 32'(m_busy));
      check("R3 xfer_req", 32'(xfer_req), 32'(m_req));
      check("R4 xfer_cmd", xfer_cmd, m_cmd);
      check("R5 warn", 32'(warn), 32'(m_warn));
      check("R7 error", 32'(error), 32'(m_err));
      check("R8 err_code", 32'(err_code), 32'(m_code));
      check("R9 ready", 32'(ready), 32'(m_rdy));
    end
    cyc++;
    if (xfer_req === 1'b1) begin
      if (first_ticks < 0) first_ticks = tks;
      cmd_log.push_back(int'(xfer_cmd));
      req_cyc.push_back(cyc);
    end
    tick_ms = ((cyc % TDIV) == 0);
    if (start_tok != start_seen) begin
      start = 1'b1; start_seen = start_tok; tks = 0;
    end else begin
      start = 1'b0; tks += int'(tick_ms);
    end
    xfer_done = 1'b0;
    if (inj_tok != inj_seen) begin
      inj_seen = inj_tok; xfer_done = 1'b1; xfer_rdata = 32'h0;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        xfer_done = 1'b1;
        xfer_rdata = (resp_q.size() > 0) ? resp_q.pop_front() : 32'h0;
        done_cyc.push_back(cyc);
      end
    end
    if (xfer_req === 1'b1) pend = LAT;
    if (rst) pend = 0;
  end

  task automatic run(input logic [31:0] r0, r1, r2, r3, r4, output int base);
    resp_q.delete();
    resp_q.push_back(r0); resp_q.push_back(r1); resp_q.push_back(r2);
    resp_q.push_back(r3); resp_q.push_back(r4);
    base = cmd_log.size();
    first_ticks = -1;
    @(posedge clk); start_tok++;
  endtask

  task automatic finish_wait();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      if (ready || error) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int b;
    repeat (3) @(posedge clk);
    cmp_on = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", 32'(busy), 0);
    check("R1 req in reset", 32'(xfer_req), 0);
    @(posedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ready idle", 32'(ready), 0);
    check("R1 error idle", 32'(error), 0);
    check("R1 warn idle", 32'(warn), 0);
    check("R1 code idle", 32'(err_code), 0);

    // A: healthy run, garbage second reply, bit 0 clear on checked replies, stray done
    run(32'h0000_0001, 32'h1234_5678, 32'h0800_00FE, 32'h0BFF_F0FE, 32'hFFFE_001F, b);
    repeat (6) @(negedge clk);
    @(posedge clk); inj_tok++;            // R11 stray done during boot wait
    finish_wait();
    check("R9 ready after healthy run", 32'(ready), 1);
    check("R11 stray done ignored, warn low", 32'(warn), 0);
    check("R2 five requests", 32'(cmd_log.size() - b), 5);
    check("R3 ticks before first request", 32'(first_ticks), BOOT);
    check("R3 first command", 32'(cmd_log[b]), 32'h2000_0003);
    check("R4 second command", 32'(cmd_log[b+1]), 32'h2000_0000);
    check("R4 fourth command", 32'(cmd_log[b+3]), 32'h2000_0000);
    check("R4 read command", 32'(cmd_log[b+4]), 32'h8014_0000);
    check("R6 fourth request right after third reply",
          32'(req_cyc[b+3] - done_cyc[done_cyc.size()-3]), 1);
    check("R8 bits outside 16:5 ignored, code", 32'(err_code), 0);

    // B: wrong first reply only warns
    run(32'h0000_0003, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, b);
    finish_wait();
    check("R5 warn raised", 32'(warn), 1);
    check("R5 run continues to ready", 32'(ready), 1);

    // C: bad status field on third exchange
    run(32'h0000_0001, 32'h0, 32'h0C00_00FF, 32'h0800_00FF, 32'h0, b);
    finish_wait();
    check("R7 error third", 32'(error), 1);
    check("R7 code third", 32'(err_code), 1);
    check("R7 stops after three requests", 32'(cmd_log.size() - b), 3);

    // D: bad low byte on fourth exchange
    run(32'h0000_0001, 32'h0, 32'h0800_00FF, 32'h0800_007F, 32'h0, b);
    finish_wait();
    check("R7 code fourth", 32'(err_code), 2);
    check("R7 stops after four requests", 32'(cmd_log.size() - b), 4);

    // E: fault flagged in bit 16
    run(32'h0000_0001, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0001_0000, b);
    finish_wait();
    check("R8 fault error", 32'(error), 1);
    check("R8 fault code", 32'(err_code), 3);

    // F: restart from error, with start repeated mid-run
    run(32'h0000_0001, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0000_0010, b);
    repeat (3) @(negedge clk);
    check("R9 restart clears error", 32'(error), 0);
    check("R9 restart clears code", 32'(err_code), 0);
    repeat (20) @(negedge clk);
    @(posedge clk); start_tok++;
    finish_wait();
    check("R2 mid-run start ignored, ready", 32'(ready), 1);
    check("R2 mid-run start ignored, count", 32'(cmd_log.size() - b), 5);

    // G: reset mid-run
    run(32'h0000_0001, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 32'h0, b);
    repeat (40) @(negedge clk);
    @(posedge clk); rst = 1'b1;
    repeat (2) @(posedge clk); rst = 1'b0;
    b = cmd_log.size();
    repeat (60) @(negedge clk);
    check("R10 idle after reset, busy", 32'(busy), 0);
    check("R10 no request after reset", 32'(cmd_log.size() - b), 0);
    check("R10 ready low after reset", 32'(ready), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule